// File: doc/BRIEF.md
# Paged control register window

This block decodes accesses into a 4 KiB register aperture that stands in for a logical register space of 64 KiB. Aperture offsets below 0xC00 reach logical registers directly. The top 1 KiB of the aperture, from 0xC00 to 0xFFF, is a movable slot. The page number held in the control register selects which 1 KiB of the logical space appears in that slot.

The control register sits at logical offset 0x808, which is in the direct region. It holds the page field, two PIO enables, a burst length and a function select. The PIO enables, burst length and function select are driven out to the rest of the controller. The block also holds two small banks of plain 32-bit registers, one low in the logical space and one high enough that it can only be reached through the slot. Software moves the slot by rewriting the page field. The next access then uses the new page, with no wait in between.

Requests use a single-cycle valid/write/address/data handshake. Read data comes back one cycle after the read request. All data is 32 bits wide and little-endian.

Top module: `pgwin_top`

## Requirements
- R1: While rst_ni is low and after it is released, every control field is zero (page 0), every bank register is zero, and rsp_valid_o and rsp_rdata_o are zero.
- R2: An access whose aperture address is below 0xC00 reaches the logical offset equal to the aperture address.
- R3: An access whose aperture address is 0xC00 to 0xFFF reaches logical offset (page << 10) | (address & 0x3FF). With page 0 this aliases logical 0x000 to 0x3FF.
- R4: The control register is at logical 0x808. Its fields are: bit 0 system-side PIO enable, bit 1 link-side PIO enable, bits 5:4 burst length, bits 18:13 page, and bits 27:19 function select. All other bits ignore writes and read 0 (implemented mask 0x0FFFE033). Each field is driven on its output port from the cycle after the write.
- R5: A write to the page field applies to the very next request, including one in the following clock cycle.
- R6: A read request gives rsp_valid_o high with the read data on the following cycle. In every other cycle rsp_valid_o and rsp_rdata_o are 0.
- R7: A read of a logical offset that is neither the control register nor a bank word returns 0. A write to such an offset changes nothing.
- R8: Bank registers are full 32-bit read/write words. There are 8 words at logical 0x000 to 0x01C and 8 words at logical 0x4BA0 to 0x4BBC. The upper bank is reached with page 0x12 at aperture 0xFA0 to 0xFBC.
- R9: Address bits 1:0 are ignored, so each access addresses the whole word.
- R10: The control register can also be reached through the slot with page 2 at aperture 0xC08. A page written that way applies to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Aperture byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data, 0 when not valid |
| sys_pio_en_o | output | 1 | System-side PIO enable field |
| link_pio_en_o | output | 1 | Link-side PIO enable field |
| burst_len_o | output | 2 | Maximum burst length field |
| page_o | output | 6 | Current page of the slot |
| func_sel_o | output | 9 | Function select field |

## Verification
The assertions assume that req_write_i, req_addr_i and req_wdata_i carry meaningful values only when req_valid_i is high. They also assume that nothing other than a request to the control register changes the page. The stimulus changes its inputs only at the falling edge. It mixes direct, slot and unmapped addresses, writes the page both directly and through the slot, and issues back-to-back requests right after page changes. A behavioural model of the logical register space predicts the response and the control fields for every cycle.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam int unsigned APER_W  = 12;
  localparam int unsigned SLOT_W  = 10;
  localparam int unsigned PAGE_W  = 6;
  localparam int unsigned LOG_W   = PAGE_W + SLOT_W;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned FUNC_W  = 9;

  localparam logic [APER_W-1:0] SLOT_START = 12'hC00;
  localparam logic [LOG_W-1:0]  CTRL_OFS   = 16'h0808;

  // field positions within the control word
  localparam int unsigned SYS_EN_BIT  = 0;
  localparam int unsigned LINK_EN_BIT = 1;
  localparam int unsigned BURST_LSB   = 4;
  localparam int unsigned PAGE_LSB    = 13;
  localparam int unsigned FUNC_LSB    = 19;

  typedef struct packed {
    logic [FUNC_W-1:0]  func_sel;
    logic [PAGE_W-1:0]  page;
    logic [BURST_W-1:0] burst;
    logic               link_en;
    logic               sys_en;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SYS_EN_BIT]                   = c.sys_en;
    w[LINK_EN_BIT]                  = c.link_en;
    w[BURST_LSB +: BURST_W]         = c.burst;
    w[PAGE_LSB +: PAGE_W]           = c.page;
    w[FUNC_LSB +: FUNC_W]           = c.func_sel;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.sys_en   = w[SYS_EN_BIT];
    c.link_en  = w[LINK_EN_BIT];
    c.burst    = w[BURST_LSB +: BURST_W];
    c.page     = w[PAGE_LSB +: PAGE_W];
    c.func_sel = w[FUNC_LSB +: FUNC_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    ctrl_t ones;
    ones = '1;
    return ctrl_pack(ones);
  endfunction
endpackage

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
(
  input  logic [APER_W-1:0] aper_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              paged_o,
  output logic [LOG_W-1:0]  log_ofs_o
);
  localparam int unsigned PAD_W = LOG_W - APER_W;

  always_comb begin
    paged_o = (aper_i >= SLOT_START);
    if (paged_o) log_ofs_o = {page_i, aper_i[SLOT_W-1:0]};
    else         log_ofs_o = {{PAD_W{1'b0}}, aper_i};
  end
endmodule

// File: rtl/pgwin_ctrl.sv
module pgwin_ctrl
  import pgwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] word_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_unpack(wdata_i);
  end

  assign ctrl_o = ctrl_q;
  assign word_o = ctrl_pack(ctrl_q);

  // R5
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));
  // R4
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> word_o == ($past(wdata_i) & ctrl_mask()));
endmodule

// File: rtl/pgwin_bank.sv
module pgwin_bank
  import pgwin_pkg::*;
#(
  parameter logic [LOG_W-1:0] BASE  = '0,
  parameter int unsigned      WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOG_W-1:0]  ofs_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [LOG_W-1:0] SPAN = LOG_W'(WORDS * 4);

  logic [WORDS-1:0][DATA_W-1:0] mem_q;
  logic [LOG_W-1:0]             diff;
  logic [IDX_W-1:0]             idx;

  // offsets below BASE wrap to large values and miss
  assign diff  = ofs_i - BASE;
  assign hit_o = (diff < SPAN);
  assign idx   = diff[IDX_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mem_q      <= '0;
    else if (wr_i && hit_o)    mem_q[idx] <= wdata_i;
  end

  assign rdata_o = hit_o ? mem_q[idx] : '0;

  // R7
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit_o) |=> $stable(mem_q));
endmodule

// File: rtl/pgwin_top.sv
module pgwin_top
  import pgwin_pkg::*;
#(
  parameter int unsigned            BANK_NUM   = 2,
  parameter int unsigned            BANK_WORDS = 8,
  parameter logic [BANK_NUM-1:0][LOG_W-1:0] BANK_BASE = {16'h4BA0, 16'h0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [11:0]       req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              sys_pio_en_o,
  output logic              link_pio_en_o,
  output logic [1:0]        burst_len_o,
  output logic [5:0]        page_o,
  output logic [8:0]        func_sel_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] ctrl_word;
  logic              paged;
  logic [LOG_W-1:0]  log_ofs;
  logic              ctrl_hit, rd_req, wr_req, any_hit;
  logic [BANK_NUM-1:0]             bank_hit;
  logic [BANK_NUM-1:0][DATA_W-1:0] bank_rdata;
  logic [DATA_W-1:0] rd_mux;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign rd_req = req_valid_i && !req_write_i;
  assign wr_req = req_valid_i &&  req_write_i;

  pgwin_decode u_decode (
    .aper_i    (req_addr_i),
    .page_i    (ctrl.page),
    .paged_o   (paged),
    .log_ofs_o (log_ofs)
  );

  assign ctrl_hit = (log_ofs[LOG_W-1:2] == CTRL_OFS[LOG_W-1:2]);

  pgwin_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_req && ctrl_hit),
    .wdata_i (req_wdata_i),
    .ctrl_o  (ctrl),
    .word_o  (ctrl_word)
  );

  for (genvar b = 0; b < BANK_NUM; b++) begin : g_bank
    pgwin_bank #(.BASE(BANK_BASE[b]), .WORDS(BANK_WORDS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ofs_i   (log_ofs),
      .wr_i    (wr_req),
      .wdata_i (req_wdata_i),
      .hit_o   (bank_hit[b]),
      .rdata_o (bank_rdata[b])
    );
  end

  assign any_hit = ctrl_hit || (|bank_hit);

  always_comb begin
    rd_mux = ctrl_hit ? ctrl_word : '0;
    for (int b = 0; b < BANK_NUM; b++) rd_mux |= bank_rdata[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      rsp_data_q  <= rd_req ? rd_mux : '0;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rsp_data_q;
  assign sys_pio_en_o  = ctrl.sys_en;
  assign link_pio_en_o = ctrl.link_en;
  assign burst_len_o   = ctrl.burst;
  assign page_o        = ctrl.page;
  assign func_sel_o    = ctrl.func_sel;

  // R6
  rd_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o);
  // R6
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o && rsp_rdata_o == '0);
  // R7
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req && !any_hit |=> rsp_rdata_o == '0);
  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_hit, bank_hit}));
  // R3
  slot_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && paged |-> log_ofs[LOG_W-1:SLOT_W] == page_o);
  // R2
  direct_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !paged |-> log_ofs[LOG_W-1:APER_W] == '0);
endmodule

// File: tb/pgwin_top_bench.sv
module pgwin_top_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, sys_en, link_en;
  logic [31:0] rsp_rdata;
  logic [1:0] burst;
  logic [5:0] page;
  logic [8:0] func_sel;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;
  bit done = 0;

  localparam logic [31:0] MASK = 32'h0FFFE033;

  // reference model state
  logic [31:0] ref_ctrl = '0;
  logic [31:0] ref_mem [int];
  logic        exp_valid = 1'b0;
  logic [31:0] exp_rdata = '0;

  always #5 clk = ~clk;

  pgwin_top u_pgwin_top (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sys_pio_en_o(sys_en), .link_pio_en_o(link_en),
    .burst_len_o(burst), .page_o(page), .func_sel_o(func_sel)
  );

  function automatic int log_of(logic [11:0] a, logic [31:0] ctrl);
    int o;
    if (a < 12'hC00) o = int'(a);
    else o = (int'(ctrl[18:13]) << 10) | int'(a & 12'h3FF);
    return o & ~3;
  endfunction

  function automatic bit in_bank(int o);
    return (o >= 0 && o < 32) || (o >= 'h4BA0 && o < 'h4BC0);
  endfunction

  function automatic logic [31:0] lookup(int o);
    if (o == 'h808) return ref_ctrl;
    if (in_bank(o) && ref_mem.exists(o)) return ref_mem[o];
    return '0;
  endfunction

  task automatic compare(string tag);
    logic [31:0] act_c, exp_c;
    n_chk++;
    if (rsp_valid !== exp_valid || rsp_rdata !== exp_rdata) begin
      n_bad++;
      $display("FAIL %s rsp: actual valid=%0b data=%h expected valid=%0b data=%h",
               tag, rsp_valid, rsp_rdata, exp_valid, exp_rdata);
    end
    act_c = {4'h0, func_sel, page, 7'h0, burst, 2'b00, link_en, sys_en};
    exp_c = ref_ctrl;
    n_chk++;
    if (act_c !== exp_c) begin
      n_bad++;
      $display("FAIL %s ctrl: actual %h expected %h", tag, act_c, exp_c);
    end
  endtask

  // one request per cycle; inputs change at negedge
  task automatic cyc(logic v, logic w, logic [11:0] a, logic [31:0] d, string tag);
    int o;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    o = log_of(a, ref_ctrl);
    exp_valid = v && !w;
    exp_rdata = (v && !w) ? lookup(o) : '0;
    if (v && w) begin
      if (o == 'h808) ref_ctrl = d & MASK;
      else if (in_bank(o)) ref_mem[o] = d;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    cyc(1'b0, 1'b0, 12'h000, 32'h0, tag);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    cyc(1, 0, 12'h808, 0, "R1 ctrl read zero");
    cyc(1, 0, 12'h01C, 0, "R1 bank read zero");
    idle("R6 idle");

    // direct region, low bank
    for (int i = 0; i < 8; i++) cyc(1, 1, 12'(i*4), 32'h1000_0000 + i, "R8 lo write");
    for (int i = 0; i < 8; i++) cyc(1, 0, 12'(i*4), 0, "R2 lo read");
    cyc(1, 0, 12'h006, 0, "R9 low bits ignored");
    cyc(1, 1, 12'h00B, 32'hDEAD_BEEF, "R9 write with low bits");
    cyc(1, 0, 12'h008, 0, "R9 readback");

    // page 0 slot aliases the direct low region
    cyc(1, 0, 12'hC04, 0, "R3 page0 alias");
    cyc(1, 1, 12'hC10, 32'h5555_AAAA, "R3 page0 alias write");
    cyc(1, 0, 12'h010, 0, "R3 alias readback");

    // control field mask and outputs
    cyc(1, 1, 12'h808, 32'hFFFF_FFFF, "R4 all ones");
    cyc(1, 0, 12'h808, 0, "R4 masked read");
    cyc(1, 1, 12'h808, 32'h0000_0000, "R4 clear");

    // page change applied on the very next request
    cyc(1, 1, 12'h808, (32'h12 << 13) | 32'h1, "R5 set page 0x12");
    cyc(1, 1, 12'hFA0, 32'hCAFE_0001, "R5 hi write next cycle");
    cyc(1, 1, 12'hFBC, 32'hCAFE_0008, "R8 hi last word");
    cyc(1, 0, 12'hFA0, 0, "R8 hi read");
    cyc(1, 0, 12'hFBC, 0, "R8 hi read last");
    cyc(1, 0, 12'hFC0, 0, "R7 past hi bank");
    cyc(1, 0, 12'h000, 0, "R2 direct unaffected by page");

    // unimplemented offsets
    cyc(1, 1, 12'h100, 32'h1234_5678, "R7 unmapped write");
    cyc(1, 0, 12'h100, 0, "R7 unmapped read");
    cyc(1, 1, 12'h808, (32'h3F << 13), "R7 set page 0x3F");
    cyc(1, 1, 12'hFFC, 32'hFFFF_0000, "R7 top slot write");
    cyc(1, 0, 12'hFFC, 0, "R7 top slot read");

    // control register through the slot
    cyc(1, 1, 12'h808, (32'h2 << 13), "R10 set page 2");
    cyc(1, 0, 12'hC08, 0, "R10 ctrl via slot");
    cyc(1, 1, 12'hC08, (32'h12 << 13) | 32'h2, "R10 page via slot");
    cyc(1, 0, 12'hFA0, 0, "R10 next access uses new page");
    cyc(1, 0, 12'hFA4, 0, "R10 hi unwritten word");

    // back-to-back reads and gaps
    cyc(1, 0, 12'h004, 0, "R6 b2b 1");
    cyc(1, 0, 12'hFBC, 0, "R6 b2b 2");
    idle("R6 gap");
    cyc(1, 1, 12'h004, 32'h0BAD_F00D, "R6 write no rsp");
    idle("R6 gap2");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:0])
        4'd0, 4'd1, 4'd2: a = {7'h0, lfsr[8:6], 2'b00};
        4'd3, 4'd4:       a = 12'hFA0 | {7'h0, lfsr[8:6], lfsr[10:9]};
        4'd5:             a = 12'h808;
        4'd6:             a = 12'hC08;
        4'd7:             a = 12'hC00 | {5'h0, lfsr[8:6], 2'b00};
        default:          a = lfsr[27:16];
      endcase
      d = {lfsr[15:0], lfsr[31:16]};
      if (a == 12'h808 || a == 12'hC08)
        d = {4'h0, lfsr[12:4], (lfsr[13] ? 6'h12 : (lfsr[14] ? 6'h02 : 6'h00)), 7'h0, lfsr[1:0], 2'b00, lfsr[5:4]};
      cyc(lfsr[20] | lfsr[21], lfsr[22], a, d, "R3 mixed traffic");
    end

    idle("R6 final");
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule